// File: doc/BRIEF.md
# Privilege-Filtered Hardware Event Counter Bank

This block holds the programmable event counters of a processor core, numbered from index 3 up to index 3+NUM_CTR-1. Each cycle it receives one increment pulse per counter index. These pulses have already been steered to counters by upstream event-selection logic. The bank decides which pulses actually count. It checks a global per-index inhibit mask, then applies a per-counter filter. The filter picks one of five inhibit bits based on the current privilege mode and on whether virtualization is active.

Each counter holds a 64-bit count, stored as two 32-bit halves, and a six-bit control field. The control field has the five mode-filter bits and a sticky overflow flag. Software reaches all of this through a 32-bit write port and a combinational read port, each addressed by counter index and a register select. A count that wraps from all ones to zero sets its overflow flag. If that flag was clear, the wrap also sets a shared pending interrupt bit. The pending bit stays asserted until software clears it.

A width input selects how the count steps. In 64-bit mode the count is a full 64-bit incrementer. In 32-bit mode the high half advances in place of the low half while the low half sits at all ones.

Top module: `hpm_bank`

## Requirements
- R1: After reset, every count half, every control field and `irq_pend` read as zero.
- R2: Only indices 3 to 3+NUM_CTR-1 are counters. For any other index, writes are ignored, reads return zero and event pulses have no effect.
- R3: A valid counter adds one per cycle in which its `evt` bit is 1 and its `inhibit` bit is 0, unless its filter blocks it or it is written that cycle.
- R4: `priv` encodes U=0, S=1, M=3. Control field bits [4:0] are {M, S, U, VS, VU} inhibits. In M mode, bit 4 applies whatever `virt_on` is. In S mode, bit 1 applies if `virt_on` is 1 and bit 3 if it is 0. In U mode, bit 0 applies if `virt_on` is 1 and bit 2 if it is 0. A set applicable bit stops counting. `priv`=2 applies no filter.
- R5: With `xlen32`=0 the count steps as one 64-bit value, carrying from the low half into the high half.
- R6: With `xlen32`=1 and only the low half at all ones, an increment adds one to the high half and leaves the low half at all ones.
- R7: An increment of a count that is all ones in both halves sets both halves to zero. If the overflow flag (control bit 5) was clear, the flag is set and `irq_pend` rises on the next edge.
- R8: A wrap on a counter whose overflow flag is already set changes neither the flag nor `irq_pend`.
- R9: A write to any register of a counter takes effect and cancels that counter's increment in the same cycle.
- R10: `irq_pend` stays at 1 until a cycle with `irq_clr` at 1 clears it. A new overflow in the same cycle as `irq_clr` leaves it at 1.
- R11: `wr_sel`/`rd_sel` select 0 = count low half, 1 = count high half, 2 = control field in data bits [31:26] as {overflow, M, S, U, VS, VU} with other bits zero, and 3 = no register (reads zero, writes ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xlen32 | input | 1 | 1 selects 32-bit half stepping |
| priv | input | 2 | Current privilege mode (U=0, S=1, M=3) |
| virt_on | input | 1 | Virtualization active |
| inhibit | input | NUM_CTR+3 | Global per-index counting inhibit |
| evt | input | NUM_CTR+3 | Per-index increment pulses |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Counter index of write |
| wr_sel | input | 2 | Register select of write |
| wr_data | input | 32 | Write data |
| rd_idx | input | IDX_W | Counter index of read |
| rd_sel | input | 2 | Register select of read |
| rd_data | output | 32 | Read data (combinational) |
| irq_clr | input | 1 | Clears the pending interrupt |
| irq_pend | output | 1 | Sticky local-overflow interrupt request |

## Verification
Random cycles vary the mode, the virtualization flag, the sparse inhibit bits and the written filter fields together. This shows whether the right one of the five filter bits is picked for each mode pair. Preloads of all-ones halves in both width modes tell the 64-bit carry apart from the 32-bit in-place high-half step. Second wraps with the flag already set tell a flag-edge interrupt apart from one raised on every wrap. Writes and pulses that collide on one counter, together with pulses and writes to indices below 3 and above the last counter, check the priority and range rules.

// File: rtl/hpm_bank.sv
module hpm_bank #(
  parameter int NUM_CTR = 4,
  parameter int IDX_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xlen32,
  input  logic [1:0]           priv,
  input  logic                 virt_on,
  input  logic [NUM_CTR+2:0]   inhibit,
  input  logic [NUM_CTR+2:0]   evt,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [1:0]           wr_sel,
  input  logic [31:0]          wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic [1:0]           rd_sel,
  output logic [31:0]          rd_data,
  input  logic                 irq_clr,
  output logic                 irq_pend
);
  localparam int FIRST  = 3;
  localparam int HW     = 32;
  localparam int FLT_W  = 6;
  localparam int FLT_LO = HW - FLT_W;
  localparam int OVF    = FLT_W - 1;

  logic [NUM_CTR-1:0][HW-1:0]    lo_q, hi_q, lo_d, hi_d;
  logic [NUM_CTR-1:0][FLT_W-1:0] flt_q;
  logic [NUM_CTR-1:0]            hit, inc, newof;

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic blk, lo_all, hi_all;
    assign hit[k] = wr_en && wr_idx == IDX_W'(k + FIRST);
    assign blk = (priv == 2'b11 && flt_q[k][4]) ||
                 (priv == 2'b01 && (virt_on ? flt_q[k][1] : flt_q[k][3])) ||
                 (priv == 2'b00 && (virt_on ? flt_q[k][0] : flt_q[k][2]));
    assign inc[k] = evt[k+FIRST] && !inhibit[k+FIRST] && !blk && !hit[k];
    assign lo_all = &lo_q[k];
    assign hi_all = &hi_q[k];
    assign newof[k] = inc[k] && lo_all && hi_all && !flt_q[k][OVF];
    always_comb begin
      if (!xlen32)
        {hi_d[k], lo_d[k]} = {hi_q[k], lo_q[k]} + 64'd1;
      else if (lo_all && hi_all)
        {hi_d[k], lo_d[k]} = '0;
      else if (lo_all)
        {hi_d[k], lo_d[k]} = {hi_q[k] + 32'd1, lo_q[k]};
      else
        {hi_d[k], lo_d[k]} = {hi_q[k], lo_q[k] + 32'd1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q     <= '0;
      hi_q     <= '0;
      flt_q    <= '0;
      irq_pend <= 1'b0;
    end else begin
      for (int k = 0; k < NUM_CTR; k++) begin
        if (hit[k]) begin
          case (wr_sel)
            2'd0: lo_q[k] <= wr_data;
            2'd1: hi_q[k] <= wr_data;
            2'd2: flt_q[k] <= wr_data[HW-1:FLT_LO];
            default: ;
          endcase
        end else if (inc[k]) begin
          lo_q[k] <= lo_d[k];
          hi_q[k] <= hi_d[k];
          if (&{lo_q[k], hi_q[k]}) flt_q[k][OVF] <= 1'b1;
        end
      end
      if (|newof)       irq_pend <= 1'b1;
      else if (irq_clr) irq_pend <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_CTR; k++) begin
      if (rd_idx == IDX_W'(k + FIRST)) begin
        case (rd_sel)
          2'd0:    rd_data = lo_q[k];
          2'd1:    rd_data = hi_q[k];
          2'd2:    rd_data = {flt_q[k], {FLT_LO{1'b0}}};
          default: rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/hpm_bank_chk.sv
module hpm_bank_chk #(
  parameter int NUM_CTR = 4,
  parameter int IDX_W   = 5
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [1:0]                priv,
  input logic [NUM_CTR+2:0]        inhibit,
  input logic                      wr_en,
  input logic [IDX_W-1:0]          wr_idx,
  input logic [1:0]                wr_sel,
  input logic [31:0]               wr_data,
  input logic [IDX_W-1:0]          rd_idx,
  input logic [31:0]               rd_data,
  input logic                      irq_clr,
  input logic                      irq_pend,
  input logic [NUM_CTR-1:0][31:0]  lo_q,
  input logic [NUM_CTR-1:0][31:0]  hi_q,
  input logic [NUM_CTR-1:0][5:0]   flt_q,
  input logic [NUM_CTR-1:0]        newof
);
  logic wr3;
  assign wr3 = wr_en && wr_idx == IDX_W'(3);

  p_bad_idx_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_idx < IDX_W'(3) |-> rd_data == 32'd0);

  p_global_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit[3] && !wr3 |=> $stable(lo_q[0]) && $stable(hi_q[0]));

  p_m_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    priv == 2'b11 && flt_q[0][4] && !wr3 |=> $stable(lo_q[0]) && $stable(hi_q[0]));

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q[0][5] && !wr3 |=> flt_q[0][5]);

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr3 && wr_sel == 2'd0 |=> lo_q[0] == $past(wr_data));

  p_irq_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    |newof |=> irq_pend);

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pend && !irq_clr |=> irq_pend);
endmodule

bind hpm_bank hpm_bank_chk #(.NUM_CTR(NUM_CTR), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv(priv), .inhibit(inhibit),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_idx(rd_idx), .rd_data(rd_data), .irq_clr(irq_clr), .irq_pend(irq_pend),
  .lo_q(lo_q), .hi_q(hi_q), .flt_q(flt_q), .newof(newof)
);

// File: tb/tb_hpm_bank.sv
module tb_hpm_bank;
  localparam int N = 4;
  localparam int IW = 5;
  localparam int TOT = N + 3;
  localparam time TP = 10;

  logic clk = 1'b0, rst_n = 1'b0, xlen32 = 1'b0, virt_on = 1'b0;
  logic [1:0] priv = 2'b11;
  logic [TOT-1:0] inhibit = '0, evt = '0;
  logic wr_en = 1'b0, irq_clr = 1'b0;
  logic [IW-1:0] wr_idx = '0, rd_idx = '0;
  logic [1:0] wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq_pend;

  hpm_bank #(.NUM_CTR(N), .IDX_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .xlen32(xlen32), .priv(priv), .virt_on(virt_on),
    .inhibit(inhibit), .evt(evt), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_idx(rd_idx), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq_clr(irq_clr), .irq_pend(irq_pend));

  always #(TP/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] m_lo [32];
  logic [31:0] m_hi [32];
  logic [5:0]  m_f  [32];
  logic        m_irq = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(int idx, int sel);
    if (idx < 3 || idx >= TOT) return 32'd0;
    case (sel)
      0: return m_lo[idx];
      1: return m_hi[idx];
      2: return {m_f[idx], 26'd0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic m_block(logic [5:0] f);
    case (priv)
      2'b11: return f[4];
      2'b01: return virt_on ? f[1] : f[3];
      2'b00: return virt_on ? f[0] : f[2];
      default: return 1'b0;
    endcase
  endfunction

  task automatic m_step();
    logic newo = 1'b0;
    for (int k = 3; k < TOT; k++) begin
      logic hitk = wr_en && wr_idx == IW'(k);
      if (hitk) begin
        if (wr_sel == 0) m_lo[k] = wr_data;
        else if (wr_sel == 1) m_hi[k] = wr_data;
        else if (wr_sel == 2) m_f[k] = wr_data[31:26];
      end else if (evt[k] && !inhibit[k] && !m_block(m_f[k])) begin
        if (&m_lo[k] && &m_hi[k]) begin
          m_lo[k] = '0; m_hi[k] = '0;
          if (!m_f[k][5]) begin m_f[k][5] = 1'b1; newo = 1'b1; end
        end else if (xlen32) begin
          if (&m_lo[k]) m_hi[k] = m_hi[k] + 1; else m_lo[k] = m_lo[k] + 1;
        end else begin
          {m_hi[k], m_lo[k]} = {m_hi[k], m_lo[k]} + 64'd1;
        end
      end
    end
    m_irq = newo ? 1'b1 : (irq_clr ? 1'b0 : m_irq);
  endtask

  task automatic cyc(string req);
    #1;
    check({req, " read"}, rd_data, m_read(int'(rd_idx), int'(rd_sel)));
    check({req, " irq"}, {31'd0, irq_pend}, {31'd0, m_irq});
    m_step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    evt = '0; wr_en = 1'b0; irq_clr = 1'b0; inhibit = '0;
  endtask

  task automatic wr(int idx, int sel, logic [31:0] d);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_sel = 2'(sel); wr_data = d;
    cyc("R11"); idle();
  endtask

  task automatic pulse(int idx, string req);
    evt = '0; evt[idx] = 1'b1; cyc(req); idle();
  endtask

  task automatic rd(int idx, int sel, logic [31:0] exp, string req);
    rd_idx = IW'(idx); rd_sel = 2'(sel); #1;
    check(req, rd_data, exp);
  endtask

  initial begin
    #(TP * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; m_f[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 3; s++) rd(3, s, 32'd0, "R1 reset");
    check("R1 irq reset", {31'd0, irq_pend}, 32'd0);
    // R3 basic counting
    for (int i = 0; i < 5; i++) pulse(3, "R3");
    rd(3, 0, 32'd5, "R3 five pulses");
    inhibit[3] = 1'b1; evt[3] = 1'b1; cyc("R3"); idle();
    rd(3, 0, 32'd5, "R3 inhibited");
    // R2 invalid indices
    pulse(1, "R2"); wr(1, 0, 32'h1234); wr(8, 0, 32'h55);
    rd(1, 0, 32'd0, "R2 low index"); rd(8, 0, 32'd0, "R2 high index");
    // R5 64-bit carry
    wr(4, 0, 32'hFFFF_FFFF); pulse(4, "R5");
    rd(4, 0, 32'd0, "R5 low"); rd(4, 1, 32'd1, "R5 high");
    // R6 32-bit stepping
    xlen32 = 1'b1;
    wr(5, 0, 32'hFFFF_FFFF); wr(5, 1, 32'd5); pulse(5, "R6");
    rd(5, 0, 32'hFFFF_FFFF, "R6 low held"); rd(5, 1, 32'd6, "R6 high");
    xlen32 = 1'b0;
    // R7 wrap
    wr(6, 0, 32'hFFFF_FFFF); wr(6, 1, 32'hFFFF_FFFF); pulse(6, "R7");
    rd(6, 0, 32'd0, "R7 low"); rd(6, 1, 32'd0, "R7 high");
    rd(6, 2, 32'h8000_0000, "R7 flag");
    check("R7 irq", {31'd0, irq_pend}, 32'd1);
    // R10 stickiness and clear
    cyc("R10"); cyc("R10");
    check("R10 held", {31'd0, irq_pend}, 32'd1);
    irq_clr = 1'b1; cyc("R10"); idle();
    check("R10 cleared", {31'd0, irq_pend}, 32'd0);
    // R8 second wrap with flag set
    wr(6, 0, 32'hFFFF_FFFF); wr(6, 1, 32'hFFFF_FFFF); pulse(6, "R8");
    rd(6, 0, 32'd0, "R8 wrapped");
    check("R8 no irq", {31'd0, irq_pend}, 32'd0);
    // R4 mode filter
    wr(3, 0, 32'd0); wr(3, 2, 32'h4000_0000);
    priv = 2'b11; virt_on = 1'b1; pulse(3, "R4");
    rd(3, 0, 32'd0, "R4 M inhibited");
    priv = 2'b01; virt_on = 1'b0; pulse(3, "R4");
    rd(3, 0, 32'd1, "R4 S counts");
    wr(3, 2, 32'h0800_0000); virt_on = 1'b1; pulse(3, "R4");
    rd(3, 0, 32'd1, "R4 VS inhibited");
    priv = 2'b00; pulse(3, "R4");
    rd(3, 0, 32'd2, "R4 VU counts");
    // R9 write beats increment
    wr_en = 1'b1; wr_idx = IW'(3); wr_sel = 2'd0; wr_data = 32'd100; evt[3] = 1'b1;
    cyc("R9"); idle();
    rd(3, 0, 32'd100, "R9 write wins");
    // R10 set wins over clear
    wr(4, 0, 32'hFFFF_FFFF); wr(4, 1, 32'hFFFF_FFFF);
    evt[4] = 1'b1; irq_clr = 1'b1; cyc("R10"); idle();
    check("R10 set wins", {31'd0, irq_pend}, 32'd1);
    // R11 unused select
    rd(4, 3, 32'd0, "R11 select 3");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      priv = 2'($urandom); virt_on = 1'($urandom);
      if ($urandom_range(0, 63) == 0) xlen32 = ~xlen32;
      evt = TOT'($urandom);
      inhibit = TOT'($urandom) & TOT'($urandom) & TOT'($urandom);
      wr_en = ($urandom_range(0, 5) == 0);
      wr_idx = IW'($urandom_range(0, 9)); wr_sel = 2'($urandom);
      wr_data = ($urandom_range(0, 2) == 0) ? 32'hFFFF_FFFF
              : (wr_sel == 2 ? {6'($urandom) & 6'h15, 26'd0} : $urandom_range(0, 7));
      irq_clr = ($urandom_range(0, 9) == 0);
      rd_idx = IW'($urandom_range(0, 9)); rd_sel = 2'($urandom);
      cyc("R3 R4 R7 random");
    end
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule